// File: doc/BRIEF.md
# Strobe-Timed Command Bridge

This block sits between a processor bus that carries no clock and a clocked processing engine. The bus master paces every transfer with an active-low write strobe whose width it chooses. Bulk operands land in a bank of parameter registers built as level-sensitive latches. These values are never resynchronised. Software loads them long before the engine reads them, so they are settled by the time they are used.

A write to the command address does not move data. The rising (trailing) edge of that strobe sets a single request flag. Only this flag crosses into the clock domain, through a parameterised chain of flip-flops. The clocked side turns the rising edge of the synchronised request into a one-cycle start pulse. The engine then hands back an acknowledge, which clears the flag asynchronously. Software polls a busy bit on the bus and issues the next command only once that bit reads zero.

The address map is fixed by the parameters. Parameter k sits at address k, for k from 0 to N_PARAM-1. The command sits at address N_PARAM. The status word sits at address N_PARAM+1.

Top module: `strb_cmd_bridge`

## Requirements
- R1: While the write strobe is low and the address equals k (0 ≤ k < N_PARAM), slice k of `params_o` (bits k*DW+DW-1 down to k*DW) follows the write data. Once the strobe rises it keeps the last value. A write to one parameter leaves the other slices unchanged.
- R2: Parameter writes cause nothing on the clock side. No start pulse follows them, and the busy bit stays at zero.
- R3: The rising edge of the write strobe with the address at N_PARAM sets the request flag. The busy bit reads one straight away, without any clock edge.
- R4: Each command write gives exactly one start pulse, one clock cycle wide.
- R5: The acknowledge is registered. It rises on the first clock edge at which `eng_accept_i` is high while the synchronised request is high. It then clears the request flag, so busy reads zero when `eng_running_i` is low. It stays high until the synchronised request reads low.
- R6: A read with `bus_rd_n_i` low at address N_PARAM+1 returns the busy bit in bit 0 and zeros above it. Busy is the request flag OR `eng_running_i`. Any other read, or no read, returns all zeros.
- R7: While `rst_ni` is low, the request flag, the synchroniser stages and the acknowledge are zero. `start_o` is low, and busy reads zero when the engine is idle.
- R8: Take the flag rise between two clock edges. `start_o` is then high in the cycle that follows the SYNC_DEPTH-th rising clock edge after the rise, and it is low one cycle earlier.
- R9: If a command write ends while the acknowledge is high, the clear wins. The flag stays low, busy reads zero, and no further start pulse appears.
- R10: The parameter values seen on `params_o` during the start pulse equal the values written before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Engine-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | AW | Bus register address |
| bus_wdata_i | input | DW | Bus write data |
| bus_wr_n_i | input | 1 | Active-low write strobe, width set by the bus master |
| bus_rd_n_i | input | 1 | Active-low read strobe |
| bus_rdata_o | output | DW | Status read data (busy in bit 0) |
| params_o | output | N_PARAM*DW | All parameter registers, register k in slice k |
| start_o | output | 1 | One-cycle command start pulse |
| eng_accept_i | input | 1 | Engine takes the pending command |
| eng_running_i | input | 1 | Engine is executing |

## Verification
The bench sweeps the position of the trailing strobe edge across the clock period and combines it with strobe widths from under one cycle to almost two. The start pulse must land on exactly the SYNC_DEPTH-th edge after the flag rises. A chain that is one stage short or long moves the pulse by a cycle, and a broken edge detector gives a pulse that is too wide or repeated. Each command is preceded by fresh parameter writes, sampled in the middle of the strobe and again at start. A latch that misses its enable, or a decode that hits the wrong slice, therefore shows up as stale or clobbered operands. On every other command a second command write arrives while the acknowledge is held. Set-over-clear priority would then leave busy stuck high and fire a spurious second start.

// File: rtl/scb_pkg.sv
`timescale 1ns/1ps
package scb_pkg;
  // Address of the command trigger for a bank of n parameters
  function automatic int unsigned cmd_addr(input int unsigned n);
    return n;
  endfunction
  // Address of the status word
  function automatic int unsigned status_addr(input int unsigned n);
    return n + 1;
  endfunction
endpackage

// File: rtl/scb_addr_dec.sv
`timescale 1ns/1ps
module scb_addr_dec #(
  parameter int unsigned AW      = 4,
  parameter int unsigned N_PARAM = 4
) (
  input  logic [AW-1:0]      addr_i,
  output logic [N_PARAM-1:0] param_hit_o,
  output logic               cmd_hit_o,
  output logic               status_hit_o
);
  import scb_pkg::*;
  localparam logic [AW-1:0] CMD_A  = AW'(cmd_addr(N_PARAM));
  localparam logic [AW-1:0] STAT_A = AW'(status_addr(N_PARAM));

  for (genvar k = 0; k < N_PARAM; k++) begin : g_hit
    assign param_hit_o[k] = (addr_i == AW'(k));
  end
  assign cmd_hit_o    = (addr_i == CMD_A);
  assign status_hit_o = (addr_i == STAT_A);
endmodule

// File: rtl/scb_param_bank.sv
`timescale 1ns/1ps
module scb_param_bank #(
  parameter int unsigned N_PARAM = 4,
  parameter int unsigned DW      = 16
) (
  input  logic                  wr_n_i,
  input  logic [N_PARAM-1:0]    hit_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [N_PARAM*DW-1:0] params_o
);
  for (genvar k = 0; k < N_PARAM; k++) begin : g_reg
    logic [DW-1:0] lat_q;
    // open while the strobe is low and this register is addressed
    always_latch begin
      if (!wr_n_i && hit_i[k]) lat_q = wdata_i;
    end
    assign params_o[k*DW +: DW] = lat_q;
  end
endmodule

// File: rtl/scb_req_flag.sv
`timescale 1ns/1ps
module scb_req_flag (
  input  logic wr_n_i,
  input  logic cmd_hit_i,
  input  logic clr_i,
  output logic flag_o
);
  // set on trailing strobe edge, clear is asynchronous and dominant
  always_ff @(posedge wr_n_i or posedge clr_i) begin
    if (clr_i)          flag_o <= 1'b0;
    else if (cmd_hit_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/scb_sync.sv
`timescale 1ns/1ps
module scb_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] stg_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[DEPTH-2:0], d_i};
  end
  assign q_o = stg_q[DEPTH-1];
endmodule

// File: rtl/scb_start_ctl.sv
`timescale 1ns/1ps
module scb_start_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_req_i,
  input  logic accept_i,
  output logic start_o,
  output logic ack_o
);
  logic req_dly_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_dly_q <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      req_dly_q <= sync_req_i;
      ack_o     <= sync_req_i & (ack_o | accept_i);
    end
  end
  assign start_o = sync_req_i & ~req_dly_q;
endmodule

// File: rtl/strb_cmd_bridge.sv
`timescale 1ns/1ps
module strb_cmd_bridge #(
  parameter int unsigned N_PARAM    = 4,
  parameter int unsigned DW         = 16,
  parameter int unsigned AW         = 4,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         bus_addr_i,
  input  logic [DW-1:0]         bus_wdata_i,
  input  logic                  bus_wr_n_i,
  input  logic                  bus_rd_n_i,
  output logic [DW-1:0]         bus_rdata_o,
  output logic [N_PARAM*DW-1:0] params_o,
  output logic                  start_o,
  input  logic                  eng_accept_i,
  input  logic                  eng_running_i
);
  logic [N_PARAM-1:0] param_hit;
  logic cmd_hit, status_hit;
  logic req_flag, flag_clr, sync_req, ack, busy;

  scb_addr_dec #(.AW(AW), .N_PARAM(N_PARAM)) dec_i (
    .addr_i(bus_addr_i), .param_hit_o(param_hit),
    .cmd_hit_o(cmd_hit), .status_hit_o(status_hit)
  );

  scb_param_bank #(.N_PARAM(N_PARAM), .DW(DW)) bank_i (
    .wr_n_i(bus_wr_n_i), .hit_i(param_hit),
    .wdata_i(bus_wdata_i), .params_o(params_o)
  );

  assign flag_clr = ack | ~rst_ni;

  scb_req_flag flag_i (
    .wr_n_i(bus_wr_n_i), .cmd_hit_i(cmd_hit),
    .clr_i(flag_clr), .flag_o(req_flag)
  );

  scb_sync #(.DEPTH(SYNC_DEPTH)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(req_flag), .q_o(sync_req)
  );

  scb_start_ctl ctl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_req_i(sync_req),
    .accept_i(eng_accept_i), .start_o(start_o), .ack_o(ack)
  );

  assign busy        = req_flag | eng_running_i;
  assign bus_rdata_o = (!bus_rd_n_i && status_hit) ? {{(DW-1){1'b0}}, busy} : '0;
endmodule

// File: rtl/strb_cmd_bridge_chk.sv
`timescale 1ns/1ps
module strb_cmd_bridge_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic ack_i,
  input logic sync_req_i,
  input logic flag_i,
  input logic busy_i
);
  assert_start_one_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !start_i);
  assert_start_needs_sync_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> sync_req_i);
  assert_start_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> busy_i);
  assert_ack_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && sync_req_i) |=> ack_i);
  assert_ack_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_i) |-> !$past(sync_req_i));
  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> !flag_i);
  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R7: assert (!start_i && !ack_i && !flag_i);
  end
endmodule

bind strb_cmd_bridge strb_cmd_bridge_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_o), .ack_i(ack),
  .sync_req_i(sync_req), .flag_i(req_flag), .busy_i(busy)
);

// File: tb/strb_cmd_bridge_tb_top.sv
`timescale 1ns/1ps
module strb_cmd_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int D  = 3;
  localparam logic [AW-1:0] CMD_A  = AW'(NP);
  localparam logic [AW-1:0] STAT_A = AW'(NP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic wr_n = 1'b1;
  logic rd_n = 1'b1;
  logic [DW-1:0] rdata;
  logic [NP*DW-1:0] params;
  logic start;
  logic accept = 1'b0;
  logic running = 1'b0;

  int vectors = 0;
  int misses = 0;
  int pulses = 0;
  bit finished = 1'b0;
  logic [DW-1:0] expv [NP];

  strb_cmd_bridge #(.N_PARAM(NP), .DW(DW), .AW(AW), .SYNC_DEPTH(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_wr_n_i(wr_n), .bus_rd_n_i(rd_n), .bus_rdata_o(rdata),
    .params_o(params), .start_o(start), .eng_accept_i(accept),
    .eng_running_i(running)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (start) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic read_status(output logic [DW-1:0] v);
    addr = STAT_A; rd_n = 1'b0;
    #1 v = rdata;
    rd_n = 1'b1;
  endtask

  task automatic write_param(input int k, input logic [DW-1:0] v, input int ph, input int w);
    @(posedge clk);
    #(ph);
    addr = AW'(k); wdata = v; wr_n = 1'b0;
    #(w/2);
    chk(params[k*DW +: DW] == v, "R1 transparent", int'(params[k*DW +: DW]), int'(v));
    #(w - w/2);
    wr_n = 1'b1;
    #1 addr = CMD_A + 1'b1;  // park on status
    wdata = ~v;
    expv[k] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      misses++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] st;
    int widths [4] = '{2, 5, 13, 19};
    int base;
    // reset phase
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(start == 1'b0, "R7 start in reset", int'(start), 0);
    read_status(st);
    chk(st == '0, "R7 busy in reset", int'(st), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pulses == 0, "R7 no pulse after reset", pulses, 0);

    // status decode and running bit
    running = 1'b1;
    read_status(st);
    chk(st == 1, "R6 busy from running", int'(st), 1);
    addr = '0; rd_n = 1'b0;
    #1 chk(rdata == '0, "R6 non-status read", int'(rdata), 0);
    rd_n = 1'b1;
    running = 1'b0;
    read_status(st);
    chk(st == 0, "R6 idle status", int'(st), 0);

    for (int p = 1; p <= 7; p++) begin
      for (int wi = 0; wi < 4; wi++) begin
        int w = widths[wi];
        int iter = (p - 1) * 4 + wi;
        // fresh operands
        for (int k = 0; k < NP; k++)
          write_param(k, DW'(p * 37 + wi * 11 + k * 5 + 1), (p + k) % 9 + 1, widths[(wi + k) % 4]);
        base = pulses;
        repeat (D + 2) @(posedge clk);
        @(negedge clk);
        chk(pulses == base, "R2 no pulse on param write", pulses - base, 0);
        read_status(st);
        chk(st == 0, "R2 busy after param writes", int'(st), 0);
        for (int k = 0; k < NP; k++)
          chk(params[k*DW +: DW] == expv[k], "R1 hold", int'(params[k*DW +: DW]), int'(expv[k]));

        // command with trailing edge at phase p of the third cycle
        @(posedge clk);
        #(2 * CLK_PERIOD + p - w);
        addr = CMD_A; wr_n = 1'b0;
        #(w);
        wr_n = 1'b1;
        #1 read_status(st);
        chk(st == 1, "R3 busy after command", int'(st), 1);
        repeat (D - 1) @(posedge clk);
        @(negedge clk);
        chk(start == 1'b0, "R8 start not early", int'(start), 0);
        @(posedge clk);
        @(negedge clk);
        chk(start == 1'b1, "R8 start at depth", int'(start), 1);
        for (int k = 0; k < NP; k++)
          chk(params[k*DW +: DW] == expv[k], "R10 params at start",
              int'(params[k*DW +: DW]), int'(expv[k]));
        accept = 1'b1;
        @(posedge clk);
        #1 accept = 1'b0;
        read_status(st);
        chk(st == 0, "R5 ack clears flag", int'(st), 0);
        if (iter % 2 == 1) begin
          addr = CMD_A; wr_n = 1'b0;
          #2 wr_n = 1'b1;
          #1 read_status(st);
          chk(st == 0, "R9 clear beats set", int'(st), 0);
        end
        repeat (D + 4) @(posedge clk);
        @(negedge clk);
        chk(pulses - base == 1, "R4 one pulse per command", pulses - base, 1);
        read_status(st);
        chk(st == 0, "R5 idle after handshake", int'(st), 0);
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule